// File: doc/BRIEF.md
# Card Presence and Write-Protect Monitor

This block watches two socket pins: a presence pin that is low while a card sits in the socket and high when the socket is empty, and the socket's write-protect switch pin. Both pins idle high with no card. Each pin passes through a synchroniser. The block then reports both levels as status bits. It raises a sticky card-change interrupt flag whenever the presence level changes in either direction.

A host drives the block over a small register bus with a single-cycle write strobe and a combinational read mux. Reporting and edge capture work only while the host has set the monitor enable. The write-protect level is shown only while a card is present. The host polls the interrupt flag, or routes it to an interrupt line, and clears it by writing 1 to it. The bus has no data stream, so there is no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `card_detect_monitor`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the status register (address 1) reads 0x00 and the interrupt register (address 2) reads 0x00.
- R2: Bit 0 of the control register is the monitor enable. It is written by a bus write to address 0 and reads back unchanged.
- R3: While enabled, status bit 6 equals the synchronised presence level: 1 means the socket is empty and 0 means a card is inserted. It follows the pin two clocks after the pin changes.
- R4: Status bit 5 equals the synchronised write-protect level only while the monitor is enabled and status bit 6 is 0. Otherwise it reads 0.
- R5: While disabled, status bits 6 and 5 read 0, and presence transitions do not set the interrupt flag.
- R6: While enabled, each high-to-low and each low-to-high presence transition sets interrupt bit 7. The flag becomes visible three clocks after the pin changes.
- R7: Turning the enable on does not set the interrupt flag, whatever the presence level is.
- R8: The flag is sticky. A write to address 2 with bit 7 set clears it, and a write with bit 7 clear leaves it unchanged.
- R9: If a presence transition is captured in the same cycle as a clearing write, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present_n | input | 1 | Socket presence pin, low when a card is inserted |
| wr_protect | input | 1 | Write-protect switch pin |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| card_irq | output | 1 | Card-change interrupt flag |

## Verification
The capture of a presence edge and the host's clearing write can land in the same clock, and the flag must then stay set. The bench provokes this by counting the synchroniser delay and timing a clearing write to the exact cycle in which the delayed edge reaches the flag logic. It judges the outcome by reading the flag afterwards. A later clear with no edge must then take the flag to 0, which shows that the clear works on its own.

// File: rtl/cdwp_pkg.sv
package cdwp_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IRQ  = 2'd2;
  localparam int BIT_EN  = 0;
  localparam int BIT_CD  = 6;
  localparam int BIT_WP  = 5;
  localparam int BIT_IRQ = 7;
endpackage

// File: rtl/cdwp_sync.sv
module cdwp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cdwp_change_flag.sv
module cdwp_change_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic level,
  input  logic clear,
  output logic change,
  output logic flag
);
  logic level_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_prev_q <= 1'b1;
    else level_prev_q <= level;
  end

  assign change = enable && (level != level_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (change) flag <= 1'b1;
    else if (clear) flag <= 1'b0;
  end
endmodule

// File: rtl/card_detect_monitor.sv
module card_detect_monitor
  import cdwp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_present_n,
  input  logic              wr_protect,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              card_irq
);
  logic [1:0] pins_s;
  logic       pres_s, wp_s;
  logic       en_q;
  logic       irq_clear, pres_change;
  logic       stat_cd, stat_wp;

  cdwp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({card_present_n, wr_protect}),
    .q(pins_s)
  );
  assign pres_s = pins_s[1];
  assign wp_s   = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (bus_wr && bus_addr == ADDR_CTRL) en_q <= bus_wdata[BIT_EN];
  end

  assign irq_clear = bus_wr && (bus_addr == ADDR_IRQ) && bus_wdata[BIT_IRQ];

  cdwp_change_flag u_flag (
    .clk(clk), .rst_n(rst_n),
    .enable(en_q), .level(pres_s), .clear(irq_clear),
    .change(pres_change), .flag(card_irq)
  );

  assign stat_cd = en_q && pres_s;
  assign stat_wp = en_q && !pres_s && wp_s;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: bus_rdata[BIT_EN] = en_q;
      ADDR_STAT: begin
        bus_rdata[BIT_CD] = stat_cd;
        bus_rdata[BIT_WP] = stat_wp;
      end
      ADDR_IRQ:  bus_rdata[BIT_IRQ] = card_irq;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/card_detect_monitor_checker.sv
module card_detect_monitor_checker
  import cdwp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              pres_s,
  input logic              stat_cd,
  input logic              stat_wp,
  input logic              card_irq,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  AST_DISABLED_NO_CD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !stat_cd && !stat_wp); // R5
  AST_WP_NEEDS_CARD: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wp |-> en_q && !pres_s); // R4
  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && pres_s != $past(pres_s)) |=> card_irq); // R6
  AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_irq) |-> $past(en_q)); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_IRQ && bus_wdata[BIT_IRQ]
     && !(en_q && pres_s != $past(pres_s))) |=> !card_irq); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (card_irq && !(bus_wr && bus_addr == ADDR_IRQ && bus_wdata[BIT_IRQ])) |=> card_irq); // R8
endmodule

bind card_detect_monitor card_detect_monitor_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .pres_s(pres_s),
  .stat_cd(stat_cd), .stat_wp(stat_wp), .card_irq(card_irq),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/card_detect_monitor_test.sv
module card_detect_monitor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       card_present_n = 1'b1;
  logic       wr_protect = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       card_irq;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  card_detect_monitor uut (
    .clk(clk), .rst_n(rst_n), .card_present_n(card_present_n),
    .wr_protect(wr_protect), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_irq(card_irq)
  );

  // Fields: [11] enable, [10] presence pin, [9] write-protect pin,
  // [8:1] expected status byte, [0] expected interrupt flag
  localparam logic [11:0] VEC [8] = '{
    {3'b011, 8'h00, 1'b0},  // R5 disabled, empty
    {3'b001, 8'h00, 1'b0},  // R5 insertion ignored while disabled
    {3'b101, 8'h20, 1'b0},  // R7 enable with card in, R4 wp shown
    {3'b111, 8'h40, 1'b1},  // R6 removal edge, R3 empty, wp masked
    {3'b100, 8'h00, 1'b1},  // R6 insertion edge, wp low
    {3'b101, 8'h20, 1'b0},  // R4 wp high, no presence edge
    {3'b011, 8'h00, 1'b0},  // R5 disabled again
    {3'b110, 8'h40, 1'b0}   // R7 re-enable while empty
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    wait_clks(3);
    rst_n = 1'b1;
    bus_read(2'd0, rd); check("R1 ctrl reset", rd, 8'h00);
    bus_read(2'd1, rd); check("R1 status reset", rd, 8'h00);
    bus_read(2'd2, rd); check("R1 irq reset", rd, 8'h00);

    for (int v = 0; v < 8; v++) begin
      card_present_n = VEC[v][10];
      wr_protect     = VEC[v][9];
      bus_write(2'd0, {7'd0, VEC[v][11]});
      wait_clks(4);
      bus_read(2'd0, rd); check("R2 ctrl readback", rd, {7'd0, VEC[v][11]});
      bus_read(2'd1, rd); check("R3 R4 R5 status", rd, VEC[v][8:1]);
      bus_read(2'd2, rd); check("R6 R7 irq flag", rd, {VEC[v][0], 7'd0});
      bus_write(2'd2, 8'h80);
    end

    // R3 timing: status follows pin after exactly two clocks (enabled, empty)
    bus_addr = 2'd1;
    @(negedge clk); card_present_n = 1'b0;
    @(negedge clk); #1 check("R3 after one clock", bus_rdata, 8'h40);
    @(negedge clk); #1 check("R3 after two clocks", bus_rdata, 8'h00);
    // R6 timing: flag set on the third edge after the pin change
    check("R6 flag not yet", {card_irq, 7'd0}, 8'h00);
    @(negedge clk); check("R6 flag third clock", {card_irq, 7'd0}, 8'h80);

    // R8: writing 0 to bit 7 keeps the flag
    bus_write(2'd2, 8'h7f);
    bus_read(2'd2, rd); check("R8 write zero keeps", rd, 8'h80);
    bus_write(2'd2, 8'h80);
    bus_read(2'd2, rd); check("R8 clear", rd, 8'h00);

    // R9: clearing write coincides with edge capture
    bus_write(2'd0, 8'h01);
    card_present_n = 1'b1;
    wait_clks(3);
    bus_read(2'd2, rd); check("R9 flag set", rd, 8'h80);
    card_present_n = 1'b0;          // changes before edge A
    @(negedge clk);                 // after A: stage 1 updated
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h80;
    @(negedge clk);                 // after A+1: clear applied, no edge yet
    check("R8 clear before edge", {card_irq, 7'd0}, 8'h00);
    // edge now visible; keep clearing in the capture cycle
    @(negedge clk);                 // after A+2: edge and clear together
    bus_wr = 1'b0;
    check("R9 edge beats clear", {card_irq, 7'd0}, 8'h80);
    bus_write(2'd2, 8'h80);
    bus_read(2'd2, rd); check("R8 clear alone", rd, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule